// File: doc/BRIEF.md
# DMA Request/Acknowledge Pin Multiplexer

This block sits between a DMA and bus-master arbiter and a small set of four request pins and four acknowledge pins. A configuration input selects one of two modes. In direct mode the four request pins are registered and passed on as requests 0 to 3. The four acknowledge pins carry a one-hot, active-low grant for channels 0 to 3.

In coded mode the request pins are time-shared against the phase of the bus clock. Three of them carry one low channel and one high channel each. The fourth always carries channel 2. The block recovers seven request lines from them and holds each line in its own register. On the acknowledge side, three pins carry the binary number of the granted channel. The fourth carries an active-low enable for an external 3-to-8 decoder. The enable is sequenced so that it is never active while the code lines change, and the decoded acknowledges do not glitch. The pins for channels 5 to 7 are then left free for other uses.

Top module: `dmx_pin_mux`

## Requirements
- R1: Synchronous reset drives every bit of `req_o` to 0, the encoder enable inactive and the code to 0. With `coded_mode_i` low the acknowledge pins read 4'b1111.
- R2: In coded mode, request pin 3 is taken as channel 3 when a low phase of `bus_clk_i` ends and as channel 7 when a high phase ends.
- R3: In coded mode, pin 1 gives channel 1 (low phase) and channel 6 (high phase). Pin 0 gives channel 0 (low phase) and channel 5 (high phase).
- R4: Pin 2 is never time-shared. `req_o[2]` equals the pin 2 value of the previous system clock in both modes.
- R5: A time-shared pin is sampled in the last system clock of each phase, one cycle before the `bus_clk_i` change is seen. Changes earlier in that phase have no effect, and a recovered request holds until the next end of the same phase.
- R6: `req_o[4]` (the cascade channel) is always 0. One clock after direct mode is in force, `req_o[7:5]` are 0.
- R7: In coded mode, `dack_n_o[2:0]` is the binary channel number (bit 0 = decoder input A) and `dack_n_o[3]` is the active-low decoder enable.
- R8: When the grant changes while the enable is active, the enable goes inactive on the next clock. The code takes the new channel one clock later, and the enable returns one clock after that. From the idle state the code loads on the first clock and the enable comes on the second.
- R9: With `grant_valid_i` low, the enable goes inactive and the code keeps its last value.
- R10: A grant of channel 4 is never encoded. The enable stays inactive.
- R11: In direct mode, `dack_n_o` is registered one clock after the grant. Bit n is low only for a valid grant of channel n (0 to 3). For any other grant, or no grant, all bits are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| coded_mode_i | input | 1 | 1 = time-shared requests and coded acknowledge, 0 = direct |
| bus_clk_i | input | 1 | Bus clock level, synchronous to `clk`, marks the request phases |
| drq_pin_i | input | 4 | Request pins |
| grant_valid_i | input | 1 | Arbiter has a granted channel |
| grant_ch_i | input | 3 | Granted channel number |
| req_o | output | 8 | Recovered request per channel (bit = channel) |
| dack_n_o | output | 4 | Acknowledge pins: one-hot active low, or code plus enable |

## Verification
Request recovery is driven with different values on each pin in the low phase and the high phase, so a swap of the two phases or of two pins gives a wrong channel. Pins also change value in the middle of a phase, which shows whether the sample is taken at the end of the phase or earlier. On the acknowledge side, a cycle-by-cycle walk covers a grant from idle, a grant change between two channels, the grant being dropped, and a grant of the cascade channel; together these show any reordering of the enable and code steps. A table of direct-mode vectors covers each one-hot acknowledge, plus grants for channels outside 0 to 3.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

    localparam int PIN_W      = 4;
    localparam int NUM_CH     = 8;
    localparam int CH_W       = $clog2(NUM_CH);
    localparam int CASCADE_CH = 4;
    localparam int SHARED_PIN = 2;

    typedef logic [CH_W-1:0] chan_t;

    typedef enum logic [1:0] {
        ACK_OFF   = 2'd0,
        ACK_SETUP = 2'd1,
        ACK_ON    = 2'd2
    } ack_state_e;

    typedef struct packed {
        logic  en;
        chan_t code;
    } ack_code_t;

    // channel carried by a pin while the bus clock is low
    function automatic chan_t low_ch(input int p);
        return chan_t'(p);
    endfunction

    // channel carried by a pin while the bus clock is high
    function automatic chan_t high_ch(input int p);
        case (p)
            0:       return chan_t'(5);
            1:       return chan_t'(6);
            3:       return chan_t'(7);
            default: return chan_t'(p);
        endcase
    endfunction

    function automatic logic is_shared(input int p);
        return p != SHARED_PIN;
    endfunction

    function automatic logic grant_ok(input logic v, input chan_t c);
        return v && (c != chan_t'(CASCADE_CH));
    endfunction

endpackage

// File: rtl/dmx_req_recover.sv
module dmx_req_recover
    import dmx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              coded_mode_i,
    input  logic              bus_clk_i,
    input  logic [PIN_W-1:0]  pin_i,
    output logic [NUM_CH-1:0] req_o
);

    logic             bclk_q;
    logic [PIN_W-1:0] pin_q;
    logic [PIN_W-1:0] lo_q;
    logic [PIN_W-1:0] hi_q;
    logic             phase_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_q <= 1'b0;
            pin_q  <= '0;
        end else begin
            bclk_q <= bus_clk_i;
            pin_q  <= pin_i;
        end
    end

    // the bus clock level differs from last cycle: the phase in bclk_q ended
    assign phase_end = coded_mode_i && (bus_clk_i != bclk_q);

    for (genvar p = 0; p < PIN_W; p++) begin : g_pin
        if (is_shared(p)) begin : g_shared
            always_ff @(posedge clk) begin
                if (rst) begin
                    lo_q[p] <= 1'b0;
                    hi_q[p] <= 1'b0;
                end else if (!coded_mode_i) begin
                    lo_q[p] <= pin_i[p];
                    hi_q[p] <= 1'b0;
                end else if (phase_end) begin
                    if (!bclk_q) lo_q[p] <= pin_q[p];
                    else         hi_q[p] <= pin_q[p];
                end
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst) begin
                    lo_q[p] <= 1'b0;
                    hi_q[p] <= 1'b0;
                end else begin
                    lo_q[p] <= pin_i[p];
                    hi_q[p] <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        req_o = '0;
        for (int p = 0; p < PIN_W; p++) begin
            req_o[low_ch(p)] = req_o[low_ch(p)] | lo_q[p];
            if (is_shared(p))
                req_o[high_ch(p)] = req_o[high_ch(p)] | hi_q[p];
        end
        req_o[CASCADE_CH] = 1'b0;
    end

endmodule

// File: rtl/dmx_ack_coder.sv
module dmx_ack_coder
    import dmx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      coded_mode_i,
    input  logic      grant_valid_i,
    input  chan_t     grant_ch_i,
    output ack_code_t ack_o
);

    ack_state_e st_q;
    logic       en_q;
    chan_t      code_q;
    logic       tgt_ok;

    assign tgt_ok = grant_ok(grant_valid_i, grant_ch_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ACK_OFF;
            en_q   <= 1'b0;
            code_q <= '0;
        end else if (!coded_mode_i) begin
            st_q <= ACK_OFF;
            en_q <= 1'b0;
        end else begin
            case (st_q)
                ACK_ON: begin
                    if (!tgt_ok || grant_ch_i != code_q) begin
                        en_q <= 1'b0;
                        st_q <= ACK_OFF;
                    end
                end
                ACK_OFF: begin
                    if (tgt_ok) begin
                        code_q <= grant_ch_i;
                        st_q   <= ACK_SETUP;
                    end
                end
                ACK_SETUP: begin
                    if (tgt_ok && grant_ch_i == code_q) begin
                        en_q <= 1'b1;
                        st_q <= ACK_ON;
                    end else begin
                        st_q <= ACK_OFF;
                    end
                end
                default: begin
                    en_q <= 1'b0;
                    st_q <= ACK_OFF;
                end
            endcase
        end
    end

    assign ack_o.en   = en_q;
    assign ack_o.code = code_q;

endmodule

// File: rtl/dmx_ack_direct.sv
module dmx_ack_direct
    import dmx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             grant_valid_i,
    input  chan_t            grant_ch_i,
    output logic [PIN_W-1:0] dack_n_o
);

    logic [PIN_W-1:0] hot;

    always_comb begin
        hot = '0;
        for (int i = 0; i < PIN_W; i++)
            if (grant_valid_i && int'(grant_ch_i) == i) hot[i] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) dack_n_o <= '1;
        else     dack_n_o <= ~hot;
    end

endmodule

// File: rtl/dmx_pin_mux.sv
module dmx_pin_mux
    import dmx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              coded_mode_i,
    input  logic              bus_clk_i,
    input  logic [PIN_W-1:0]  drq_pin_i,
    input  logic              grant_valid_i,
    input  logic [CH_W-1:0]   grant_ch_i,
    output logic [NUM_CH-1:0] req_o,
    output logic [PIN_W-1:0]  dack_n_o
);

    ack_code_t        coded_ack;
    logic [PIN_W-1:0] direct_dack_n;

    dmx_req_recover i_req (
        .clk          (clk),
        .rst          (rst),
        .coded_mode_i (coded_mode_i),
        .bus_clk_i    (bus_clk_i),
        .pin_i        (drq_pin_i),
        .req_o        (req_o)
    );

    dmx_ack_coder i_coder (
        .clk           (clk),
        .rst           (rst),
        .coded_mode_i  (coded_mode_i),
        .grant_valid_i (grant_valid_i),
        .grant_ch_i    (grant_ch_i),
        .ack_o         (coded_ack)
    );

    dmx_ack_direct i_direct (
        .clk           (clk),
        .rst           (rst),
        .grant_valid_i (grant_valid_i),
        .grant_ch_i    (grant_ch_i),
        .dack_n_o      (direct_dack_n)
    );

    // code pins carry the channel number, the top pin the active-low enable
    assign dack_n_o = coded_mode_i ? {~coded_ack.en, coded_ack.code} : direct_dack_n;

endmodule

// File: rtl/dmx_pin_mux_chk.sv
module dmx_pin_mux_chk
    import dmx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              coded_mode_i,
    input logic [PIN_W-1:0]  drq_pin_i,
    input logic [NUM_CH-1:0] req_o,
    input logic [PIN_W-1:0]  dack_n_o
);

    // R8: code lines only move while the enable is inactive on both sides
    p_code_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) && coded_mode_i && $past(coded_mode_i) && !$stable(dack_n_o[CH_W-1:0])
        |-> dack_n_o[CH_W] && $past(dack_n_o[CH_W]));

    // R10: an active enable never comes with the cascade code
    p_no_cascade_r10: assert property (@(posedge clk) disable iff (rst)
        coded_mode_i && !dack_n_o[CH_W] |-> dack_n_o[CH_W-1:0] != CH_W'(CASCADE_CH));

    // R4: the unshared pin follows its input with one clock of delay
    p_plain_pin_r4: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> req_o[SHARED_PIN] == $past(drq_pin_i[SHARED_PIN]));

    // R6: cascade request never set; high channels clear in direct mode
    p_high_clear_r6: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) && !$past(coded_mode_i) |-> req_o[NUM_CH-1:CASCADE_CH] == '0);

    // R11: direct acknowledges are at most one active
    p_direct_onehot_r11: assert property (@(posedge clk) disable iff (rst)
        !coded_mode_i |-> $countones(~dack_n_o) <= 1);

endmodule

bind dmx_pin_mux dmx_pin_mux_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .coded_mode_i (coded_mode_i),
    .drq_pin_i    (drq_pin_i),
    .req_o        (req_o),
    .dack_n_o     (dack_n_o)
);

// File: tb/test_dmx_pin_mux.sv
`timescale 1ns/1ps
module test_dmx_pin_mux;

    logic       clk = 1'b0;
    logic       rst;
    logic       coded;
    logic       bclk;
    logic [3:0] pins;
    logic       gv;
    logic [2:0] gch;
    logic [7:0] req;
    logic [3:0] dack_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    dmx_pin_mux i_dmx_pin_mux (
        .clk           (clk),
        .rst           (rst),
        .coded_mode_i  (coded),
        .bus_clk_i     (bclk),
        .drq_pin_i     (pins),
        .grant_valid_i (gv),
        .grant_ch_i    (gch),
        .req_o         (req),
        .dack_n_o      (dack_n)
    );

    // {pins[3:0], valid, ch[2:0], expected req[3:0], expected dack_n[3:0]}
    localparam logic [15:0] DIR_VEC [0:7] = '{
        16'b0001_1_000_0001_1110,
        16'b0010_1_001_0010_1101,
        16'b0100_1_010_0100_1011,
        16'b1000_1_011_1000_0111,
        16'b1111_1_101_1111_1111,
        16'b0101_1_100_0101_1111,
        16'b1010_0_010_1010_1111,
        16'b0000_1_011_0000_0111
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic b, input logic [3:0] p);
        bclk = b;
        pins = p;
        step();
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
        end
    end

    initial begin
        rst = 1'b1; coded = 1'b0; bclk = 1'b0; pins = 4'h0; gv = 1'b0; gch = 3'd0;
        step(); step();
        chk("R1 req reset", 32'(req), 32'h00);
        chk("R1 dack reset", 32'(dack_n), 32'hF);
        rst = 1'b0;

        // direct mode table: outputs one clock after each vector
        for (int i = 0; i < 8; i++) begin
            pins = DIR_VEC[i][15:12];
            gv   = DIR_VEC[i][11];
            gch  = DIR_VEC[i][10:8];
            step();
            chk("R11 direct dack", 32'(dack_n), 32'(DIR_VEC[i][3:0]));
            chk("R4 direct req low", 32'(req[3:0]), 32'(DIR_VEC[i][7:4]));
            chk("R6 direct req high", 32'(req[7:4]), 32'h0);
        end

        // coded mode, idle acknowledge: enable off, code 0
        gv = 1'b0; gch = 3'd0; coded = 1'b1;
        drive(1'b1, 4'h0);
        drive(1'b1, 4'h0);
        chk("R9 idle coded dack", 32'(dack_n), 32'h8);

        // low phase ends with pins 1011
        drive(1'b0, 4'h0); drive(1'b0, 4'h0); drive(1'b0, 4'h0);
        drive(1'b0, 4'b1011);
        drive(1'b1, 4'b0100);
        chk("R2 R3 low phase ch0 ch1 ch3", 32'(req), 32'h0F);
        drive(1'b1, 4'b1011);
        drive(1'b1, 4'b1011);
        chk("R5 mid-phase change ignored", 32'(req), 32'h0B);
        drive(1'b1, 4'b0001);
        drive(1'b0, 4'b1010);
        chk("R3 high phase ch5", 32'(req), 32'h2B);
        drive(1'b0, 4'b1010);
        drive(1'b0, 4'b1000);
        drive(1'b1, 4'b0000);
        chk("R2 low phase ch3 only", 32'(req), 32'h28);
        drive(1'b1, 4'b1000);
        drive(1'b0, 4'b0010);
        chk("R2 high phase ch7", 32'(req), 32'h88);
        drive(1'b0, 4'b0000);
        drive(1'b1, 4'b0000);
        chk("R5 low channels cleared", 32'(req), 32'h80);
        drive(1'b1, 4'b0010);
        drive(1'b0, 4'b0100);
        chk("R3 R4 high phase ch6 and ch2", 32'(req), 32'h44);
        chk("R6 cascade request zero", 32'(req[4]), 32'h0);

        // coded acknowledge sequencing
        gv = 1'b1; gch = 3'd3;
        step();
        chk("R8 code loads, enable off", 32'(dack_n), 32'b1011);
        step();
        chk("R7 enable on for ch3", 32'(dack_n), 32'b0011);
        gch = 3'd5;
        step();
        chk("R8 enable drops first", 32'(dack_n), 32'b1011);
        step();
        chk("R8 code changes next", 32'(dack_n), 32'b1101);
        step();
        chk("R8 enable returns", 32'(dack_n), 32'b0101);
        gv = 1'b0;
        step();
        chk("R9 no grant enable off", 32'(dack_n), 32'b1101);
        step(); step();
        chk("R9 code holds", 32'(dack_n), 32'b1101);
        gv = 1'b1; gch = 3'd4;
        step(); step(); step();
        chk("R10 cascade not encoded", 32'(dack_n), 32'b1101);
        gch = 3'd6;
        step();
        chk("R8 from idle code first", 32'(dack_n), 32'b1110);
        step();
        chk("R7 enable on for ch6", 32'(dack_n), 32'b0110);

        // back to direct mode
        coded = 1'b0;
        step();
        chk("R11 ch6 no direct ack", 32'(dack_n), 32'hF);
        chk("R6 high requests cleared", 32'(req[7:4]), 32'h0);

        rst = 1'b1;
        step();
        chk("R1 req after reset", 32'(req), 32'h00);
        chk("R1 dack after reset", 32'(dack_n), 32'hF);
        rst = 1'b0;

        done = 1'b1;
        summary();
    end

endmodule